// File: doc/BRIEF.md
# Memory Test Pattern Engine

A built-in tester that drives one synchronous single-port RAM. Each access takes one cycle, and read data appears on the cycle after the read. A start pulse launches one of two test types. The data test runs a fixed series of patterns. In each step it writes the pattern to every location in ascending order, then reads every location back and compares.

The address test first clears the whole memory. It then writes a marker value at one indicated address and scans every location. Only the indicated address may return the marker, and every other location must return zero. The indicated address walks from zero through each power of two.

On every miscompare the engine records the 1-based step number, the address, the expected word, the read word and their XOR map. A halt-on-error input chooses between stopping at the first miscompare and counting every miscompare through to the end. A completed run pulses done. A pass flag reports whether the run found no miscompare.

Top module: `memtest_engine`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, halted_o, err_valid_o and mem_en_o are 0 and err_count_o is 0.
- R2: With DATA_W=16 and mode_i=0, the data test has 24 steps. Its patterns are, in order: 0000, 5555, AAAA, CCCC, 3333, 6666, 9999, FFFF, then a single one walking from bit 0 (0001) to bit 15 (8000). Each step writes addresses 0 to 2^ADDR_W-1 on consecutive cycles, then reads the same range on consecutive cycles, then leaves one idle cycle. The first write appears in the cycle after the start edge.
- R3: With DATA_W=8 the data test has 13 steps, with patterns 00, AA, 55, CC, 33, then a single one walking from 01 to 80.
- R4: With mode_i=1 the address test has ADDR_W+1 steps. The indicated address is 0 in step 1 and 2^(k-2) in step k. Each step writes zero to every address in ascending order, then writes MARKER (default 00AA) once at the indicated address, then reads every address in ascending order, then leaves one idle cycle.
- R5: In the address test, the indicated address is expected to read MARKER and every other address is expected to read zero.
- R6: A miscompare on a read issued in cycle c raises err_valid_o for one cycle in cycle c+2. err_step_o holds the 1-based step number, err_addr_o the address, err_exp_o the expected word, err_got_o the read word, and err_map_o their bitwise XOR.
- R7: With halt_on_err_i=0 at start, every miscompare increments err_count_o and the run completes all steps.
- R8: With halt_on_err_i=1 at start, the first miscompare stops the run. Exactly one more memory cycle or idle cycle follows the failing read. halted_o then stays 1 with the memory port idle until the next start, and done_o does not pulse.
- R9: done_o pulses for one cycle in the cycle after the last idle cycle of a completed run. pass_o goes to 1 at that point only if the run saw no miscompare, and it holds until the next start.
- R10: start_i, mode_i and halt_on_err_i are ignored while busy_o is 1. A run can be started from the idle or halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run when idle or halted |
| mode_i | input | 1 | 0 = data test, 1 = address test |
| halt_on_err_i | input | 1 | 1 = stop at first miscompare |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write (1) or read (0) |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at run completion |
| pass_o | output | 1 | Last completed run saw no miscompare |
| halted_o | output | 1 | Stopped on a miscompare |
| err_valid_o | output | 1 | One-cycle pulse per recorded miscompare |
| err_step_o | output | STEP_W | Step number of last miscompare (1-based) |
| err_addr_o | output | ADDR_W | Address of last miscompare |
| err_exp_o | output | DATA_W | Expected word of last miscompare |
| err_got_o | output | DATA_W | Read word of last miscompare |
| err_map_o | output | DATA_W | XOR of read and expected words |
| err_count_o | output | CNT_W | Number of miscompares in this run |

## Verification
The bench models the RAM with injectable faults: a bit stuck at one on a single address, and an address line short that mirrors each write to a second location. A reference model predicts every memory cycle and every error record, and both are compared on every clock. It checks the exact cycle of err_valid_o against the one-cycle read latency; a design off by one would report the neighbouring address or a stale expected word. The halting runs check that the last read has no second report and that the port goes quiet. A design that compared during the halt would count 2 errors. A design that left out the idle cycle before the next fill would lose the compare of the final address. A mid-run start pulse with a different mode must leave the run unchanged. A small byte-wide instance confirms the 13-entry pattern order.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_MARK,
    ST_SCAN,
    ST_DRAIN,
    ST_HALT
  } state_e;

  // steps in the data test for a given word width
  function automatic int unsigned data_steps(input int unsigned w);
    return (w == 8) ? 13 : w + 8;
  endfunction

  // fixed nibble patterns, replicated across the word
  function automatic logic [3:0] word_nib(input int unsigned i);
    case (i)
      0: return 4'h0;
      1: return 4'h5;
      2: return 4'hA;
      3: return 4'hC;
      4: return 4'h3;
      5: return 4'h6;
      6: return 4'h9;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] byte_nib(input int unsigned i);
    case (i)
      0: return 4'h0;
      1: return 4'hA;
      2: return 4'h5;
      3: return 4'hC;
      default: return 4'h3;
    endcase
  endfunction

endpackage

// File: rtl/memtest_pattern_rom.sv
module memtest_pattern_rom #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 8
) (
  input  logic [STEP_W-1:0] idx_i,
  output logic [DATA_W-1:0] pat_o
);
  import memtest_pkg::*;

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  generate
    if (DATA_W == 8) begin : g_byte
      localparam int unsigned NFIX = 5;
      always_comb begin
        if (idx_i < STEP_W'(NFIX)) pat_o = {(DATA_W/4){byte_nib(int'(idx_i))}};
        else                       pat_o = ONE << (idx_i - STEP_W'(NFIX));
      end
    end else begin : g_word
      localparam int unsigned NFIX = 8;
      always_comb begin
        if (idx_i < STEP_W'(NFIX)) pat_o = {(DATA_W/4){word_nib(int'(idx_i))}};
        else                       pat_o = ONE << (idx_i - STEP_W'(NFIX));
      end
    end
  endgenerate

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 8,
  parameter logic [DATA_W-1:0] MARKER = 'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              halt_on_err_i,
  input  logic              mismatch_i,
  input  logic              err_none_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic [STEP_W-1:0] pat_idx_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              rd_issue_o,
  output logic [DATA_W-1:0] rd_exp_o,
  output logic [STEP_W-1:0] rd_step_o,
  output logic              hold_o,
  output logic              clear_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              halted_o
);
  import memtest_pkg::*;

  localparam int unsigned DAT_STEPS = data_steps(DATA_W);
  localparam int unsigned ADR_STEPS = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  state_e            st_q;
  logic [STEP_W-1:0] step_q, last_step;
  logic [ADDR_W-1:0] addr_q, mark_addr;
  logic              mode_q, halt_q, done_q, pass_q;
  logic              launch, stop;

  assign last_step = mode_q ? STEP_W'(ADR_STEPS - 1) : STEP_W'(DAT_STEPS - 1);
  assign mark_addr = (step_q == '0) ? '0 : A_ONE << (step_q - STEP_W'(1));
  assign launch    = start_i && (st_q == ST_IDLE || st_q == ST_HALT);
  assign stop      = mismatch_i && halt_q;
  assign pat_idx_o = step_q;

  always_comb begin
    mem_en_o    = (st_q == ST_FILL) || (st_q == ST_MARK) || (st_q == ST_SCAN);
    mem_we_o    = (st_q == ST_FILL) || (st_q == ST_MARK);
    mem_addr_o  = (st_q == ST_MARK) ? mark_addr : addr_q;
    mem_wdata_o = '0;
    if (st_q == ST_MARK)                 mem_wdata_o = MARKER;
    else if (st_q == ST_FILL && !mode_q) mem_wdata_o = pat_i;
  end

  assign rd_issue_o = (st_q == ST_SCAN);
  assign rd_exp_o   = mode_q ? ((addr_q == mark_addr) ? MARKER : '0) : pat_i;
  assign rd_step_o  = step_q + STEP_W'(1);
  assign hold_o     = (st_q == ST_HALT);
  assign clear_o    = launch;
  assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_HALT);
  assign halted_o   = (st_q == ST_HALT);
  assign done_o     = done_q;
  assign pass_o     = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      addr_q <= '0;
      mode_q <= 1'b0;
      halt_q <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        st_q   <= ST_FILL;
        step_q <= '0;
        addr_q <= '0;
        mode_q <= mode_i;
        halt_q <= halt_on_err_i;
        pass_q <= 1'b0;
      end else begin
        case (st_q)
          ST_FILL: begin
            addr_q <= addr_q + A_ONE;
            if (addr_q == LAST_ADDR) st_q <= mode_q ? ST_MARK : ST_SCAN;
          end
          ST_MARK: st_q <= ST_SCAN;
          ST_SCAN: begin
            if (stop) st_q <= ST_HALT;
            else begin
              addr_q <= addr_q + A_ONE;
              if (addr_q == LAST_ADDR) st_q <= ST_DRAIN;
            end
          end
          ST_DRAIN: begin
            // last read of the step is compared here
            if (stop) st_q <= ST_HALT;
            else if (step_q == last_step) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              pass_q <= err_none_i && !mismatch_i;
            end else begin
              step_q <= step_q + STEP_W'(1);
              st_q   <= ST_FILL;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/memtest_cmp.sv
module memtest_cmp #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              hold_i,
  input  logic              rd_issue_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_exp_i,
  input  logic [STEP_W-1:0] rd_step_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o,
  output logic              err_none_o,
  output logic              err_valid_o,
  output logic [STEP_W-1:0] err_step_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_got_o,
  output logic [DATA_W-1:0] err_map_o,
  output logic [CNT_W-1:0]  err_count_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic [STEP_W-1:0] step_q;

  // read data lines up with the request one cycle later
  assign mismatch_o = vld_q && !hold_i && (rdata_i != exp_q);
  assign err_none_o = (err_count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
      step_q <= '0;
    end else begin
      vld_q  <= rd_issue_i && !clear_i;
      addr_q <= rd_addr_i;
      exp_q  <= rd_exp_i;
      step_q <= rd_step_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o <= 1'b0;
      err_step_o  <= '0;
      err_addr_o  <= '0;
      err_exp_o   <= '0;
      err_got_o   <= '0;
      err_map_o   <= '0;
      err_count_o <= '0;
    end else begin
      err_valid_o <= 1'b0;
      if (clear_i) begin
        err_count_o <= '0;
      end else if (mismatch_o) begin
        err_valid_o <= 1'b1;
        err_step_o  <= step_q;
        err_addr_o  <= addr_q;
        err_exp_o   <= exp_q;
        err_got_o   <= rdata_i;
        err_map_o   <= rdata_i ^ exp_q;
        if (err_count_o != '1) err_count_o <= err_count_o + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter logic [DATA_W-1:0] MARKER = 'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              halt_on_err_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              halted_o,
  output logic              err_valid_o,
  output logic [STEP_W-1:0] err_step_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_got_o,
  output logic [DATA_W-1:0] err_map_o,
  output logic [CNT_W-1:0]  err_count_o
);
  logic [STEP_W-1:0] pat_idx, rd_step;
  logic [DATA_W-1:0] pat, rd_exp;
  logic              rd_issue, hold, clear, mismatch, err_none;

  memtest_pattern_rom #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_rom (
    .idx_i (pat_idx),
    .pat_o (pat)
  );

  memtest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .MARKER(MARKER)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .mode_i        (mode_i),
    .halt_on_err_i (halt_on_err_i),
    .mismatch_i    (mismatch),
    .err_none_i    (err_none),
    .pat_i         (pat),
    .pat_idx_o     (pat_idx),
    .mem_en_o      (mem_en_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .rd_issue_o    (rd_issue),
    .rd_exp_o      (rd_exp),
    .rd_step_o     (rd_step),
    .hold_o        (hold),
    .clear_o       (clear),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .pass_o        (pass_o),
    .halted_o      (halted_o)
  );

  memtest_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .hold_i      (hold),
    .rd_issue_i  (rd_issue),
    .rd_addr_i   (mem_addr_o),
    .rd_exp_i    (rd_exp),
    .rd_step_i   (rd_step),
    .rdata_i     (mem_rdata_i),
    .mismatch_o  (mismatch),
    .err_none_o  (err_none),
    .err_valid_o (err_valid_o),
    .err_step_o  (err_step_o),
    .err_addr_o  (err_addr_o),
    .err_exp_o   (err_exp_o),
    .err_got_o   (err_got_o),
    .err_map_o   (err_map_o),
    .err_count_o (err_count_o)
  );

endmodule

// File: rtl/memtest_engine_chk.sv
module memtest_engine_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              halted_o,
  input logic              mem_en_o,
  input logic              err_valid_o,
  input logic [DATA_W-1:0] err_map_o,
  input logic [CNT_W-1:0]  err_count_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);
  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!mem_en_o && !busy_o && !done_o));
  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> halted_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  pass_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (err_count_o == '0));
  // R6
  err_map_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> (err_map_o != '0));
  // R10
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o || halted_o));
endmodule

bind memtest_engine memtest_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/memtest_engine_bench.sv
`timescale 1ns/1ps
module memtest_engine_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int D  = 1 << AW;
  localparam logic [DW-1:0] MARK = 16'h00AA;

  typedef struct packed {
    logic          en, we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          busy, done, errv;
    logic [7:0]    estep;
    logic [AW-1:0] eaddr;
    logic [DW-1:0] eexp, egot;
  } op_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, mode = 0, halt = 0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wd, mem_rd;
  logic busy, done, pass, halted, errv;
  logic [7:0]    estep;
  logic [AW-1:0] eaddr;
  logic [DW-1:0] eexp, egot, emap;
  logic [15:0]   ecnt;

  always #4 clk = ~clk;

  memtest_engine #(.ADDR_W(AW), .DATA_W(DW)) u_memtest_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .halt_on_err_i(halt),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wd),
    .mem_rdata_i(mem_rd), .busy_o(busy), .done_o(done), .pass_o(pass), .halted_o(halted),
    .err_valid_o(errv), .err_step_o(estep), .err_addr_o(eaddr), .err_exp_o(eexp),
    .err_got_o(egot), .err_map_o(emap), .err_count_o(ecnt));

  // byte-wide instance
  logic b_start = 0;
  logic b_en, b_we, b_busy, b_done, b_pass, b_halted, b_errv;
  logic [3:0] b_addr, b_eaddr;
  logic [7:0] b_wd, b_rd, b_estep, b_eexp, b_egot, b_emap;
  logic [15:0] b_cnt;

  memtest_engine #(.ADDR_W(4), .DATA_W(8)) u_memtest_engine_byte (
    .clk_i(clk), .rst_ni(rst_n), .start_i(b_start), .mode_i(1'b0), .halt_on_err_i(1'b0),
    .mem_en_o(b_en), .mem_we_o(b_we), .mem_addr_o(b_addr), .mem_wdata_o(b_wd),
    .mem_rdata_i(b_rd), .busy_o(b_busy), .done_o(b_done), .pass_o(b_pass), .halted_o(b_halted),
    .err_valid_o(b_errv), .err_step_o(b_estep), .err_addr_o(b_eaddr), .err_exp_o(b_eexp),
    .err_got_o(b_egot), .err_map_o(b_emap), .err_count_o(b_cnt));

  // RAM models with injectable faults
  logic [DW-1:0] ram [D];
  logic [DW-1:0] rmem [D];
  logic [7:0]    bram [16];
  int            alias_mask = 0;
  int            sa_addr = -1;
  logic [DW-1:0] sa_bits = '0;
  logic [7:0]    byte_seen [$];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        ram[mem_addr] <= mem_wd;
        if (alias_mask != 0) ram[mem_addr ^ alias_mask[AW-1:0]] <= mem_wd;
      end else begin
        mem_rd <= ram[mem_addr] | ((int'(mem_addr) == sa_addr) ? sa_bits : '0);
      end
    end
    if (b_en) begin
      if (b_we) begin
        bram[b_addr] <= b_wd;
        if (b_addr == 4'd0) byte_seen.push_back(b_wd);
      end else b_rd <= bram[b_addr];
    end
  end

  int n_cmp = 0, n_bad = 0;
  op_t ops[$];
  int  exp_cnt;
  bit  exp_halt;
  op_t exp_last;

  task automatic chk(input bit ok, input string msg);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [DW-1:0] ref_pat(input int s);
    logic [DW-1:0] fixed [8];
    fixed = '{16'h0000, 16'h5555, 16'hAAAA, 16'hCCCC, 16'h3333, 16'h6666, 16'h9999, 16'hFFFF};
    if (s < 8) return fixed[s];
    return DW'(1) << (s - 8);
  endfunction

  function automatic logic [7:0] ref_byte(input int s);
    logic [7:0] fixed [5];
    fixed = '{8'h00, 8'hAA, 8'h55, 8'hCC, 8'h33};
    if (s < 5) return fixed[s];
    return 8'(1) << (s - 5);
  endfunction

  task automatic ref_write(input int a, input logic [DW-1:0] d);
    rmem[a] = d;
    if (alias_mask != 0) rmem[a ^ alias_mask] = d;
  endtask

  function automatic logic [DW-1:0] ref_read(input int a);
    return rmem[a] | ((a == sa_addr) ? sa_bits : '0);
  endfunction

  task automatic push_op(input bit en, input bit we, input int a, input logic [DW-1:0] d,
                         input bit bz, input bit dn);
    op_t o;
    o = '0;
    o.en = en; o.we = we; o.addr = AW'(a); o.wd = d; o.busy = bz; o.done = dn;
    ops.push_back(o);
  endtask

  task automatic build_ref(input bit md, input bit hl);
    int nst;
    int m;
    logic [DW-1:0] p, e, g;
    bit stopped;
    int eidx [$];
    op_t erec [$];
    op_t r;
    nst = md ? AW + 1 : DW + 8;
    stopped = 0;
    exp_cnt = 0;
    ops.delete();
    for (int s = 0; s < nst && !stopped; s++) begin
      m = (s == 0) ? 0 : (1 << (s - 1));
      p = ref_pat(s);
      for (int a = 0; a < D; a++) begin
        push_op(1, 1, a, md ? '0 : p, 1, 0);
        ref_write(a, md ? '0 : p);
      end
      if (md) begin
        push_op(1, 1, m, MARK, 1, 0);
        ref_write(m, MARK);
      end
      for (int a = 0; a < D && !stopped; a++) begin
        e = md ? ((a == m) ? MARK : '0) : p;
        g = ref_read(a);
        push_op(1, 0, a, '0, 1, 0);
        if (g !== e) begin
          r = '0;
          r.errv = 1; r.estep = 8'(s + 1); r.eaddr = AW'(a); r.eexp = e; r.egot = g;
          eidx.push_back(ops.size() + 1);
          erec.push_back(r);
          exp_last = r;
          exp_cnt++;
          if (hl) begin
            stopped = 1;
            if (a < D - 1) push_op(1, 0, a + 1, '0, 1, 0);
            else           push_op(0, 0, 0, '0, 1, 0);
          end
        end
      end
      if (!stopped) push_op(0, 0, 0, '0, 1, 0);
    end
    push_op(0, 0, 0, '0, 0, !stopped);
    exp_halt = stopped;
    foreach (eidx[k]) begin
      if (eidx[k] < ops.size()) begin
        ops[eidx[k]].errv  = 1;
        ops[eidx[k]].estep = erec[k].estep;
        ops[eidx[k]].eaddr = erec[k].eaddr;
        ops[eidx[k]].eexp  = erec[k].eexp;
        ops[eidx[k]].egot  = erec[k].egot;
      end
    end
  endtask

  // poke >= 0: pulse start with flipped mode/halt at that cycle (must be ignored)
  task automatic run_test(input string tag, input bit md, input bit hl, input int poke);
    op_t e;
    bit ok;
    build_ref(md, hl);
    @(negedge clk);
    start = 1; mode = md; halt = hl;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < ops.size(); i++) begin
      e = ops[i];
      ok = (mem_en === e.en) && (busy === e.busy) && (done === e.done) && (errv === e.errv);
      if (e.en) ok = ok && (mem_we === e.we) && (mem_addr === e.addr);
      if (e.en && e.we) ok = ok && (mem_wd === e.wd);
      if (e.errv) ok = ok && (estep === e.estep) && (eaddr === e.eaddr) && (eexp === e.eexp)
                     && (egot === e.egot) && (emap === (e.eexp ^ e.egot));
      chk(ok, $sformatf("%s cycle %0d: got en%0b we%0b a=%h d=%h busy%0b done%0b ev%0b st=%0d ea=%h ee=%h eg=%h em=%h; exp en%0b we%0b a=%h d=%h busy%0b done%0b ev%0b st=%0d ea=%h ee=%h eg=%h",
        tag, i, mem_en, mem_we, mem_addr, mem_wd, busy, done, errv, estep, eaddr, eexp, egot, emap,
        e.en, e.we, e.addr, e.wd, e.busy, e.done, e.errv, e.estep, e.eaddr, e.eexp, e.egot));
      if (i == poke) begin start = 1; mode = !md; halt = !hl; end
      @(negedge clk);
      if (i == poke) begin start = 0; mode = md; halt = hl; end
    end
    // R9 done is a single pulse; pass/halt/count settle
    chk(done === 1'b0 && pass === (!exp_halt && exp_cnt == 0) && halted === exp_halt
        && int'(ecnt) == exp_cnt,
        $sformatf("%s R9/R7 end: done=%0b pass=%0b halted=%0b cnt=%0d; exp done=0 pass=%0b halted=%0b cnt=%0d",
        tag, done, pass, halted, ecnt, (!exp_halt && exp_cnt == 0), exp_halt, exp_cnt));
    if (exp_cnt > 0)
      chk(eaddr === exp_last.eaddr && eexp === exp_last.eexp && egot === exp_last.egot,
          $sformatf("%s R6 last record: a=%h e=%h g=%h; exp a=%h e=%h g=%h",
          tag, eaddr, eexp, egot, exp_last.eaddr, exp_last.eexp, exp_last.egot));
    if (exp_halt) begin
      repeat (5) @(negedge clk);
      chk(halted === 1'b1 && mem_en === 1'b0 && busy === 1'b0,
          $sformatf("%s R8 hold: halted=%0b en=%0b busy=%0b; exp 1 0 0", tag, halted, mem_en, busy));
    end
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin ram[i] = '0; rmem[i] = '0; end
    for (int i = 0; i < 16; i++) bram[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && pass === 0 && halted === 0 && errv === 0 && mem_en === 0 && ecnt === 0,
        $sformatf("R1 in reset: busy%0b done%0b pass%0b halt%0b ev%0b en%0b cnt%0d; exp all 0",
        busy, done, pass, halted, errv, mem_en, ecnt));
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(busy === 0 && done === 0 && pass === 0 && halted === 0 && mem_en === 0 && b_en === 0,
        $sformatf("R1 after reset: busy%0b done%0b pass%0b halt%0b en%0b ben%0b; exp all 0",
        busy, done, pass, halted, mem_en, b_en));

    run_test("R2/R10 data clean", 0, 0, 300);
    run_test("R4/R5 addr clean", 1, 0, 40);

    sa_addr = 'h2C; sa_bits = 16'h0008;
    run_test("R6/R7 data stuck continue", 0, 0, -1);
    run_test("R8 data stuck halt", 0, 1, -1);
    sa_addr = -1; sa_bits = '0;

    alias_mask = 'h10;
    run_test("R5/R7 addr alias continue", 1, 0, -1);
    run_test("R8 addr alias halt", 1, 1, -1);
    alias_mask = 0;

    run_test("R9 rerun after halt", 0, 0, -1);

    // R3 byte-wide pattern list
    byte_seen.delete();
    @(negedge clk); b_start = 1;
    @(negedge clk); b_start = 0;
    for (int i = 0; i < 3000 && !b_done; i++) @(negedge clk);
    chk(b_done === 1'b1 && b_pass === 1'b1,
        $sformatf("R3 byte run end: done=%0b pass=%0b; exp 1 1", b_done, b_pass));
    chk(byte_seen.size() == 13,
        $sformatf("R3 byte step count: %0d; exp 13", byte_seen.size()));
    for (int s = 0; s < 13 && s < byte_seen.size(); s++)
      chk(byte_seen[s] === ref_byte(s),
          $sformatf("R3 byte step %0d pattern: %h; exp %h", s + 1, byte_seen[s], ref_byte(s)));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements), got hang, exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule